// File: doc/BRIEF.md
# DDR3 Mode Register Programming Sequencer

This block writes the four DDR3 mode registers. The caller supplies the configuration as separate fields: burst length and order, read and write latencies, write recovery, DLL controls, additive latency, write leveling, strobe termination, output disable, self-refresh options and the calibration-pattern readout. From these fields the block packs four opcode words. It then issues one mode-register-set command per register. The bank-address output selects the register and the address output carries its opcode.

A sequence starts on a start-up request, made once the power-on delays have elapsed, or on a later reprogram request. Every field of every register is written on each pass, even when only one field changes. The configuration is captured in the cycle the request is accepted. A command is held back while any bank is open or a burst is in flight. A command that sets the DLL reset bit is also held back while the clock enable is low. Once the mode-register settling time has passed after the last command, the block raises done. A configuration with an unsupported read latency, write latency or write recovery is refused with an error flag, and no command is sent.

Top module: `ddr_mrs_sequencer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `mrs_o`, `done_o` and `err_o` are 0, and `bank_sel_o` and `cmd_addr_o` are all zeros.
- R2: An accepted request produces exactly four commands, with `bank_sel_o` taking the values 2, 3, 1, 0 in that order.
- R3: The first command follows the accepting edge by one cycle when the gate is open. Successive commands rise exactly `TMRD` cycles apart when nothing stalls them. `done_o` rises `TMOD` cycles after the last command and stays high until the next accepted request, and no command is issued while it is high.
- R4: `mrs_o` rises only at an edge where `banks_idle_i` was 1 and `burst_busy_i` was 0. Otherwise the pending command waits, and no command is dropped.
- R5: The word for register 0 places the burst-length code (`cfg_burst_len`, 0 = fixed eight, 1 = chosen per access, 2 = chop to four) in bits 1:0. Bit 3 is interleaved order, bits 6:4 hold CL−4 for CL 5 to 10, and bit 8 is DLL reset (forced to 1 on start-up, taken from `cfg_dll_reset` on reprogram). Bit 12 is fast exit from precharge power-down. Every other bit is 0.
- R6: Write recovery is coded into bits 11:9 of the word for register 0 as 5→1, 6→2, 7→3, 8→4, 10→5 and 12→6.
- R7: The word for register 1 has bit 0 = DLL disable, bits 4:3 = additive-latency select, bit 7 = write leveling, bit 11 = strobe termination enable and bit 12 = output disable. All other bits are 0.
- R8: The word for register 2 has bits 5:3 = CWL−5 for CWL 5 to 10, bit 6 = automatic self-refresh and bit 7 = extended temperature range. All other bits are 0.
- R9: The word for register 3 has bit 2 = calibration-pattern readout enable and bits 1:0 = pattern select when that enable is 1. Bits 1:0 are 00 when it is 0, whatever the select input. All other bits are 0.
- R10: A request with CL outside 5 to 10, write recovery outside {5,6,7,8,10,12}, or CWL outside 5 to 10 sets `err_o` at the accepting edge, clears `done_o`, and issues no command. The next accepted valid request clears `err_o`.
- R11: A register-0 command with bit 8 set is issued only at an edge where `clk_en_i` was 1. With bit 8 clear, `clk_en_i` has no effect.
- R12: Requests made while a sequence runs are ignored. Configuration changes after acceptance do not alter the words being issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-up request (forces DLL reset); wins over reprogram |
| reprog_i | input | 1 | Reprogram request |
| banks_idle_i | input | 1 | All banks precharged and idle |
| burst_busy_i | input | 1 | A read or write burst is in flight |
| clk_en_i | input | 1 | Current level of the memory clock enable |
| cfg_burst_len | input | 2 | Burst-length code |
| cfg_interleave | input | 1 | 1 = interleaved burst order |
| cfg_cas_lat | input | 4 | Read latency in clocks |
| cfg_wr_rec | input | 4 | Write recovery in clocks |
| cfg_pd_fast_exit | input | 1 | DLL kept running in precharge power-down |
| cfg_dll_reset | input | 1 | DLL reset bit used on reprogram |
| cfg_dll_off | input | 1 | DLL disable |
| cfg_add_lat | input | 2 | Additive latency select (0, CL−1, CL−2) |
| cfg_wr_level | input | 1 | Write leveling enable |
| cfg_term_strobe_en | input | 1 | Termination strobe enable |
| cfg_out_off | input | 1 | Tri-state the data outputs |
| cfg_cas_wr_lat | input | 4 | Write latency in clocks |
| cfg_auto_selfref | input | 1 | Automatic self-refresh enable |
| cfg_ext_temp | input | 1 | Extended self-refresh temperature range |
| cfg_cal_read_en | input | 1 | Calibration-pattern readout enable |
| cfg_cal_pattern | input | 2 | Calibration pattern select |
| mrs_o | output | 1 | One-cycle mode-register-set command strobe |
| bank_sel_o | output | BA_W | Target register number, valid with `mrs_o` |
| cmd_addr_o | output | ADDR_W | Opcode word, valid with `mrs_o` |
| done_o | output | 1 | Programming finished |
| err_o | output | 1 | Last request refused |

## Verification
On every cycle, the assertions check the issue interlock against bank state, bursts and the clock enable, and the minimum spacing between commands. They also check that no reserved bit of any opcode is ever set, that the calibration select is zero while readout is off, and that `done_o` and `err_o` never overlap. The exact non-linear codes for write recovery and latencies, the register order, and the exact settling delay before done are shown only by the bench. So are the snapshot of the configuration at acceptance and the refusal of bad configurations. The bench compares every output against its reference model on every clock and inspects the logged commands after each scenario.

// File: rtl/ddr_mrs_pkg.sv
package ddr_mrs_pkg;

  localparam int unsigned NUM_MR = 4;

  typedef struct packed {
    logic [1:0] burst_len;
    logic       interleave;
    logic [3:0] cas_lat;
    logic [3:0] wr_rec;
    logic       pd_fast;
    logic       dll_reset;
    logic       dll_off;
    logic [1:0] add_lat;
    logic       wr_level;
    logic       term_strobe;
    logic       out_off;
    logic [3:0] cas_wr_lat;
    logic       auto_selfref;
    logic       ext_temp;
    logic       cal_en;
    logic [1:0] cal_pattern;
  } mrs_cfg_t;

  typedef struct packed {
    logic       ok;
    logic [2:0] code;
  } fld_code_t;

  // read latency: 5..10 -> 1..6
  function automatic fld_code_t enc_cas_lat(input logic [3:0] v);
    fld_code_t r;
    r.ok   = (v >= 4'd5) && (v <= 4'd10);
    r.code = r.ok ? 3'(v - 4'd4) : 3'd0;
    return r;
  endfunction

  // write latency: 5..10 -> 0..5
  function automatic fld_code_t enc_cas_wr_lat(input logic [3:0] v);
    fld_code_t r;
    r.ok   = (v >= 4'd5) && (v <= 4'd10);
    r.code = r.ok ? 3'(v - 4'd5) : 3'd0;
    return r;
  endfunction

  // write recovery: non-linear map, gaps at 9 and 11
  function automatic fld_code_t enc_wr_rec(input logic [3:0] v);
    fld_code_t r;
    r.ok = 1'b1;
    case (v)
      4'd5:    r.code = 3'd1;
      4'd6:    r.code = 3'd2;
      4'd7:    r.code = 3'd3;
      4'd8:    r.code = 3'd4;
      4'd10:   r.code = 3'd5;
      4'd12:   r.code = 3'd6;
      default: begin r.code = 3'd0; r.ok = 1'b0; end
    endcase
    return r;
  endfunction

  // issue order of registers: 2, 3, 1, 0 (0 last, carries DLL reset)
  function automatic logic [1:0] seq_target(input logic [1:0] step);
    case (step)
      2'd0:    return 2'd2;
      2'd1:    return 2'd3;
      2'd2:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/mrs_field_pack.sv
module mrs_field_pack
  import ddr_mrs_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  mrs_cfg_t                        cfg_i,
  output logic [NUM_MR-1:0][ADDR_W-1:0]   mr_word_o,
  output logic                            cfg_ok_o
);

  fld_code_t cl_c;
  fld_code_t wr_c;
  fld_code_t cwl_c;

  always_comb begin
    cl_c  = enc_cas_lat(cfg_i.cas_lat);
    wr_c  = enc_wr_rec(cfg_i.wr_rec);
    cwl_c = enc_cas_wr_lat(cfg_i.cas_wr_lat);

    mr_word_o = '0;

    // register 0
    mr_word_o[0][1:0]  = cfg_i.burst_len;
    mr_word_o[0][3]    = cfg_i.interleave;
    mr_word_o[0][6:4]  = cl_c.code;
    mr_word_o[0][8]    = cfg_i.dll_reset;
    mr_word_o[0][11:9] = wr_c.code;
    mr_word_o[0][12]   = cfg_i.pd_fast;

    // register 1: unlisted bits stay zero
    mr_word_o[1][0]    = cfg_i.dll_off;
    mr_word_o[1][4:3]  = cfg_i.add_lat;
    mr_word_o[1][7]    = cfg_i.wr_level;
    mr_word_o[1][11]   = cfg_i.term_strobe;
    mr_word_o[1][12]   = cfg_i.out_off;

    // register 2
    mr_word_o[2][5:3]  = cwl_c.code;
    mr_word_o[2][6]    = cfg_i.auto_selfref;
    mr_word_o[2][7]    = cfg_i.ext_temp;

    // register 3: pattern select only meaningful with readout on
    mr_word_o[3][2]    = cfg_i.cal_en;
    mr_word_o[3][1:0]  = cfg_i.cal_en ? cfg_i.cal_pattern : 2'b00;

    cfg_ok_o = cl_c.ok & wr_c.ok & cwl_c.ok;
  end

endmodule

// File: rtl/mrs_issue_ctrl.sv
module mrs_issue_ctrl
  import ddr_mrs_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BA_W   = 3,
  parameter int unsigned TMRD   = 4,
  parameter int unsigned TMOD   = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_i,
  input  logic                          cfg_ok_i,
  input  logic [NUM_MR-1:0][ADDR_W-1:0] words_i,
  input  logic                          banks_idle_i,
  input  logic                          burst_busy_i,
  input  logic                          clk_en_i,
  output logic                          mrs_o,
  output logic [BA_W-1:0]               bank_sel_o,
  output logic [ADDR_W-1:0]             cmd_addr_o,
  output logic                          done_o,
  output logic                          err_o
);

  localparam int unsigned CNT_MAX = (TMRD > TMOD) ? TMRD : TMOD;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [1:0]  LAST_STEP = 2'(NUM_MR - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_SETTLE} st_t;

  st_t               st_q;
  logic [1:0]        step_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] word_q [NUM_MR];
  logic              mrs_q;
  logic [BA_W-1:0]   bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic              err_q;

  logic [1:0]        tgt;
  logic [ADDR_W-1:0] cur_word;
  logic              dll_hold;
  logic              gate_open;
  logic              fire;
  logic              accept;

  always_comb begin
    tgt       = seq_target(step_q);
    cur_word  = word_q[tgt];
    dll_hold  = (tgt == 2'd0) && cur_word[8] && !clk_en_i;
    gate_open = banks_idle_i && !burst_busy_i;
    fire      = (st_q == ST_ISSUE) && (cnt_q == '0) && gate_open && !dll_hold;
    accept    = (st_q == ST_IDLE) && req_i && cfg_ok_i;
  end

  // opcode snapshot: plain enabled registers, no reset needed
  for (genvar g = 0; g < NUM_MR; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (accept) word_q[g] <= words_i[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      cnt_q  <= '0;
      mrs_q  <= 1'b0;
      bank_q <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      mrs_q <= 1'b0;
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (req_i) begin
            done_q <= 1'b0;
            err_q  <= !cfg_ok_i;
            if (cfg_ok_i) begin
              step_q <= '0;
              st_q   <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (fire) begin
            mrs_q  <= 1'b1;
            bank_q <= BA_W'(tgt);
            addr_q <= cur_word;
            if (step_q == LAST_STEP) begin
              cnt_q <= CNT_W'(TMOD - 1);
              st_q  <= ST_SETTLE;
            end else begin
              cnt_q  <= CNT_W'(TMRD - 1);
              step_q <= step_q + 2'd1;
            end
          end
        end
        ST_SETTLE: begin
          if (cnt_q == '0) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mrs_o      = mrs_q;
  assign bank_sel_o = bank_q;
  assign cmd_addr_o = addr_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

endmodule

// File: rtl/ddr_mrs_sequencer.sv
module ddr_mrs_sequencer
  import ddr_mrs_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BA_W   = 3,
  parameter int unsigned TMRD   = 4,
  parameter int unsigned TMOD   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              reprog_i,
  input  logic              banks_idle_i,
  input  logic              burst_busy_i,
  input  logic              clk_en_i,
  input  logic [1:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic [3:0]        cfg_cas_lat,
  input  logic [3:0]        cfg_wr_rec,
  input  logic              cfg_pd_fast_exit,
  input  logic              cfg_dll_reset,
  input  logic              cfg_dll_off,
  input  logic [1:0]        cfg_add_lat,
  input  logic              cfg_wr_level,
  input  logic              cfg_term_strobe_en,
  input  logic              cfg_out_off,
  input  logic [3:0]        cfg_cas_wr_lat,
  input  logic              cfg_auto_selfref,
  input  logic              cfg_ext_temp,
  input  logic              cfg_cal_read_en,
  input  logic [1:0]        cfg_cal_pattern,
  output logic              mrs_o,
  output logic [BA_W-1:0]   bank_sel_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              done_o,
  output logic              err_o
);

  mrs_cfg_t                        cfg;
  logic [NUM_MR-1:0][ADDR_W-1:0]   words;
  logic                            cfg_ok;

  always_comb begin
    cfg.burst_len    = cfg_burst_len;
    cfg.interleave   = cfg_interleave;
    cfg.cas_lat      = cfg_cas_lat;
    cfg.wr_rec       = cfg_wr_rec;
    cfg.pd_fast      = cfg_pd_fast_exit;
    cfg.dll_reset    = start_i | cfg_dll_reset;  // start-up always resets DLL
    cfg.dll_off      = cfg_dll_off;
    cfg.add_lat      = cfg_add_lat;
    cfg.wr_level     = cfg_wr_level;
    cfg.term_strobe  = cfg_term_strobe_en;
    cfg.out_off      = cfg_out_off;
    cfg.cas_wr_lat   = cfg_cas_wr_lat;
    cfg.auto_selfref = cfg_auto_selfref;
    cfg.ext_temp     = cfg_ext_temp;
    cfg.cal_en       = cfg_cal_read_en;
    cfg.cal_pattern  = cfg_cal_pattern;
  end

  mrs_field_pack #(.ADDR_W(ADDR_W)) u_pack (
    .cfg_i     (cfg),
    .mr_word_o (words),
    .cfg_ok_o  (cfg_ok)
  );

  mrs_issue_ctrl #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .TMRD   (TMRD),
    .TMOD   (TMOD)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_i        (start_i | reprog_i),
    .cfg_ok_i     (cfg_ok),
    .words_i      (words),
    .banks_idle_i (banks_idle_i),
    .burst_busy_i (burst_busy_i),
    .clk_en_i     (clk_en_i),
    .mrs_o        (mrs_o),
    .bank_sel_o   (bank_sel_o),
    .cmd_addr_o   (cmd_addr_o),
    .done_o       (done_o),
    .err_o        (err_o)
  );

endmodule

// File: rtl/mrs_seq_checker.sv
module mrs_seq_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BA_W   = 3,
  parameter int unsigned TMRD   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              banks_idle_i,
  input logic              burst_busy_i,
  input logic              clk_en_i,
  input logic              mrs_o,
  input logic [BA_W-1:0]   bank_sel_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic              done_o,
  input logic              err_o
);

  localparam logic [ADDR_W-1:0] KEEP0 = ADDR_W'(16'h1F7B);
  localparam logic [ADDR_W-1:0] KEEP1 = ADDR_W'(16'h1899);
  localparam logic [ADDR_W-1:0] KEEP2 = ADDR_W'(16'h00F8);
  localparam logic [ADDR_W-1:0] KEEP3 = ADDR_W'(16'h0007);
  localparam int unsigned GAP_W = $clog2(TMRD + 1);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)                         gap_q <= GAP_W'(TMRD);
    else if (mrs_o)                  gap_q <= GAP_W'(1);
    else if (gap_q < GAP_W'(TMRD))   gap_q <= gap_q + 1'b1;
  end

  AST_GATE_OPEN: assert property (@(posedge clk) disable iff (rst)
    mrs_o |-> $past(banks_idle_i && !burst_busy_i)); // R4
  AST_MRS_SPACING: assert property (@(posedge clk) disable iff (rst)
    mrs_o |-> (gap_q >= GAP_W'(TMRD))); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !mrs_o); // R3
  AST_TARGET_RANGE: assert property (@(posedge clk) disable iff (rst)
    mrs_o |-> (bank_sel_o < BA_W'(4))); // R2
  AST_MR0_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mrs_o && bank_sel_o == '0) |-> ((cmd_addr_o & ~KEEP0) == '0)); // R5
  AST_CL_CODE: assert property (@(posedge clk) disable iff (rst)
    (mrs_o && bank_sel_o == '0) |-> (cmd_addr_o[6:4] != 3'd0 && cmd_addr_o[6:4] != 3'd7)); // R5
  AST_WR_CODE: assert property (@(posedge clk) disable iff (rst)
    (mrs_o && bank_sel_o == '0) |-> (cmd_addr_o[11:9] != 3'd0 && cmd_addr_o[11:9] != 3'd7)); // R6
  AST_MR1_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mrs_o && bank_sel_o == BA_W'(1)) |-> ((cmd_addr_o & ~KEEP1) == '0)); // R7
  AST_MR2_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mrs_o && bank_sel_o == BA_W'(2)) |-> ((cmd_addr_o & ~KEEP2) == '0)); // R8
  AST_MR3_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mrs_o && bank_sel_o == BA_W'(3)) |-> ((cmd_addr_o & ~KEEP3) == '0)); // R9
  AST_PATTERN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (mrs_o && bank_sel_o == BA_W'(3) && !cmd_addr_o[2]) |-> (cmd_addr_o[1:0] == 2'b00)); // R9
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o)); // R10
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> !mrs_o); // R10
  AST_DLL_RESET_CKE: assert property (@(posedge clk) disable iff (rst)
    (mrs_o && bank_sel_o == '0 && cmd_addr_o[8]) |-> $past(clk_en_i)); // R11

endmodule

bind ddr_mrs_sequencer mrs_seq_checker #(
  .ADDR_W (ADDR_W),
  .BA_W   (BA_W),
  .TMRD   (TMRD)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .banks_idle_i (banks_idle_i),
  .burst_busy_i (burst_busy_i),
  .clk_en_i     (clk_en_i),
  .mrs_o        (mrs_o),
  .bank_sel_o   (bank_sel_o),
  .cmd_addr_o   (cmd_addr_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/tb_ddr_mrs_sequencer.sv
module tb_ddr_mrs_sequencer;

  localparam int ADDR_W = 16;
  localparam int BA_W   = 3;
  localparam int TMRD   = 4;
  localparam int TMOD   = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, reprog_i = 0, banks_idle_i = 1, burst_busy_i = 0, clk_en_i = 1;
  logic [1:0] c_bl = 0;  logic c_il = 0;  logic [3:0] c_cl = 6;  logic [3:0] c_wr = 8;
  logic c_ppd = 0, c_dllr = 0, c_dlloff = 0;  logic [1:0] c_al = 0;
  logic c_wl = 0, c_tdqs = 0, c_qoff = 0;  logic [3:0] c_cwl = 6;
  logic c_asr = 0, c_srt = 0, c_cal = 0;  logic [1:0] c_sel = 0;

  logic              mrs_o;
  logic [BA_W-1:0]   bank_sel_o;
  logic [ADDR_W-1:0] cmd_addr_o;
  logic              done_o, err_o;

  always #2 clk = ~clk;  // 250 MHz

  ddr_mrs_sequencer #(.ADDR_W(ADDR_W), .BA_W(BA_W), .TMRD(TMRD), .TMOD(TMOD)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .reprog_i(reprog_i),
    .banks_idle_i(banks_idle_i), .burst_busy_i(burst_busy_i), .clk_en_i(clk_en_i),
    .cfg_burst_len(c_bl), .cfg_interleave(c_il), .cfg_cas_lat(c_cl), .cfg_wr_rec(c_wr),
    .cfg_pd_fast_exit(c_ppd), .cfg_dll_reset(c_dllr), .cfg_dll_off(c_dlloff),
    .cfg_add_lat(c_al), .cfg_wr_level(c_wl), .cfg_term_strobe_en(c_tdqs),
    .cfg_out_off(c_qoff), .cfg_cas_wr_lat(c_cwl), .cfg_auto_selfref(c_asr),
    .cfg_ext_temp(c_srt), .cfg_cal_read_en(c_cal), .cfg_cal_pattern(c_sel),
    .mrs_o(mrs_o), .bank_sel_o(bank_sel_o), .cmd_addr_o(cmd_addr_o),
    .done_o(done_o), .err_o(err_o)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, t_done = 0;
  int log_ba[$], log_w[$], log_t[$];
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------- reference model, written from the requirements ----------
  function automatic int wr_code(input int v);
    case (v) 5: return 1; 6: return 2; 7: return 3; 8: return 4; 10: return 5; 12: return 6;
      default: return -1; endcase
  endfunction

  function automatic bit cfg_valid();
    return (c_cl >= 5 && c_cl <= 10) && (wr_code(int'(c_wr)) > 0) && (c_cwl >= 5 && c_cwl <= 10);
  endfunction

  function automatic int mr_word(input int mr, input bit dll);
    case (mr)
      0: return int'(c_bl) | (int'(c_il) << 3) | ((int'(c_cl) - 4) << 4) | (int'(dll) << 8)
              | (wr_code(int'(c_wr)) << 9) | (int'(c_ppd) << 12);
      1: return int'(c_dlloff) | (int'(c_al) << 3) | (int'(c_wl) << 7) | (int'(c_tdqs) << 11)
              | (int'(c_qoff) << 12);
      2: return ((int'(c_cwl) - 5) << 3) | (int'(c_asr) << 6) | (int'(c_srt) << 7);
      default: return c_cal ? (4 | int'(c_sel)) : 0;
    endcase
  endfunction

  int m_st = 0, m_cnt = 0, m_step = 0;
  int m_w[4];
  int e_mrs = 0, e_ba = 0, e_addr = 0, e_done = 0, e_err = 0;
  int order[4] = '{2, 3, 1, 0};

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_step = 0;
      e_mrs = 0; e_ba = 0; e_addr = 0; e_done = 0; e_err = 0;
    end else begin
      e_mrs = 0;
      if (m_st == 0) begin
        if (start_i || reprog_i) begin
          e_done = 0;
          if (!cfg_valid()) e_err = 1;
          else begin
            e_err = 0;
            for (int i = 0; i < 4; i++) m_w[i] = mr_word(i, start_i ? 1'b1 : c_dllr);
            m_step = 0; m_st = 1;
          end
        end
      end else if (m_st == 1) begin
        int tgt;
        bit hold;
        tgt  = order[m_step];
        hold = (tgt == 0) && m_w[0][8] && !clk_en_i;
        if (m_cnt == 0 && banks_idle_i && !burst_busy_i && !hold) begin
          e_mrs = 1; e_ba = tgt; e_addr = m_w[tgt];
          if (m_step == 3) begin m_st = 2; m_cnt = TMOD - 1; end
          else begin m_step++; m_cnt = TMRD - 1; end
        end else if (m_cnt > 0) m_cnt--;
      end else begin
        if (m_cnt == 0) begin e_done = 1; m_st = 0; end
        else m_cnt--;
      end
    end
  end

  // ---------- per-cycle comparison and command log ----------
  logic prev_done = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst && !finished) begin
      check("R3 mrs_o", int'(mrs_o), e_mrs);
      check("R2 bank_sel_o", int'(bank_sel_o), e_ba);
      check("R5 cmd_addr_o", int'(cmd_addr_o), e_addr);
      check("R3 done_o", int'(done_o), e_done);
      check("R10 err_o", int'(err_o), e_err);
      if (mrs_o) begin
        log_ba.push_back(int'(bank_sel_o));
        log_w.push_back(int'(cmd_addr_o));
        log_t.push_back(cyc);
      end
      if (done_o && !prev_done) t_done = cyc;
      prev_done = done_o;
    end
    if (cyc > 150000 && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // ---------- stimulus helpers ----------
  task automatic clear_log();
    log_ba.delete(); log_w.delete(); log_t.delete();
  endtask

  task automatic request(input bit st);
    @(negedge clk); start_i = st; reprog_i = !st;
    @(negedge clk); start_i = 0; reprog_i = 0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 300; i++) begin
      if (done_o || err_o) break;
      @(negedge clk);
    end
  endtask

  task automatic run(input bit st);
    clear_log(); request(st); wait_end(); @(negedge clk);
  endtask

  task automatic cfg_a();
    c_bl = 0; c_il = 0; c_cl = 6; c_wr = 8; c_ppd = 1; c_dllr = 0; c_dlloff = 0; c_al = 1;
    c_wl = 0; c_tdqs = 0; c_qoff = 0; c_cwl = 6; c_asr = 1; c_srt = 0; c_cal = 0; c_sel = 0;
  endtask

  initial begin
    cfg_a();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 mrs_o", int'(mrs_o), 0);
    check("R1 done_o", int'(done_o), 0);
    check("R1 err_o", int'(err_o), 0);
    check("R1 bank_sel_o", int'(bank_sel_o), 0);
    check("R1 cmd_addr_o", int'(cmd_addr_o), 0);
    rst = 0;
    @(negedge clk);

    // S1 start-up: order, words, spacing, settle time
    run(1);
    check("R2 count", log_ba.size(), 4);
    if (log_ba.size() == 4) begin
      check("R2 first", log_ba[0], 2); check("R2 second", log_ba[1], 3);
      check("R2 third", log_ba[2], 1); check("R2 fourth", log_ba[3], 0);
      check("R8 word2", log_w[0], 'h48);
      check("R9 word3", log_w[1], 'h0);
      check("R7 word1", log_w[2], 'h08);
      check("R5 word0", log_w[3], 'h1920);
      check("R3 gap1", log_t[1] - log_t[0], TMRD);
      check("R3 gap3", log_t[3] - log_t[2], TMRD);
      check("R3 settle", t_done - log_t[3], TMOD);
    end
    check("R3 done held", int'(done_o), 1);

    // S2 reprogram with every field flipped
    c_bl = 2; c_il = 1; c_cl = 10; c_wr = 12; c_ppd = 0; c_dllr = 0; c_dlloff = 1; c_al = 2;
    c_wl = 1; c_tdqs = 1; c_qoff = 1; c_cwl = 10; c_asr = 0; c_srt = 1; c_cal = 1; c_sel = 2;
    run(0);
    if (log_w.size() == 4) begin
      check("R8 word2 alt", log_w[0], 'hA8);
      check("R9 word3 alt", log_w[1], 'h6);
      check("R7 word1 alt", log_w[2], 'h1891);
      check("R5 word0 alt", log_w[3], 'hC6A);
    end else check("R2 count alt", log_w.size(), 4);

    // S3 write recovery sweep
    cfg_a();
    foreach (order[k]) begin end
    for (int v = 5; v <= 12; v++) begin
      if (v == 9 || v == 11) continue;
      c_wr = 4'(v);
      run(0);
      if (log_w.size() == 4) check("R6 wr code", (log_w[3] >> 9) & 7, (v <= 8) ? v - 4 : (v == 10 ? 5 : 6));
      else check("R6 count", log_w.size(), 4);
    end
    c_wr = 8;

    // S4 read latency sweep
    for (int v = 5; v <= 10; v++) begin
      c_cl = 4'(v);
      run(0);
      if (log_w.size() == 4) check("R5 cl code", (log_w[3] >> 4) & 7, v - 4);
      else check("R5 count", log_w.size(), 4);
    end
    c_cl = 6;

    // S5 refused configurations
    for (int k = 0; k < 6; k++) begin
      cfg_a();
      case (k) 0: c_cl = 4; 1: c_cl = 11; 2: c_wr = 9; 3: c_wr = 11; 4: c_cwl = 4; default: c_cwl = 11; endcase
      run(0);
      check("R10 err set", int'(err_o), 1);
      check("R10 no done", int'(done_o), 0);
      check("R10 no command", log_ba.size(), 0);
    end
    cfg_a();
    run(0);
    check("R10 err cleared", int'(err_o), 0);
    check("R10 done after", int'(done_o), 1);

    // S6 pattern select ignored when readout is off
    c_cal = 0; c_sel = 3;
    run(0);
    if (log_w.size() == 4) check("R9 pattern ignored", log_w[1], 0);
    c_sel = 0;

    // S7 interlock on banks and bursts
    clear_log();
    banks_idle_i = 0;
    request(0);
    repeat (20) @(negedge clk);
    check("R4 banks open", log_ba.size(), 0);
    banks_idle_i = 1; burst_busy_i = 1;
    repeat (20) @(negedge clk);
    check("R4 burst busy", log_ba.size(), 0);
    burst_busy_i = 0;
    for (int i = 0; i < 20 && log_ba.size() == 0; i++) @(negedge clk);
    burst_busy_i = 1;
    repeat (15) @(negedge clk);
    check("R4 mid stall", log_ba.size(), 1);
    burst_busy_i = 0;
    wait_end(); @(negedge clk);
    check("R4 none dropped", log_ba.size(), 4);

    // S8 DLL reset waits for clock enable
    clk_en_i = 0;
    clear_log(); request(1);
    repeat (60) @(negedge clk);
    check("R11 held count", log_ba.size(), 3);
    check("R11 no done", int'(done_o), 0);
    clk_en_i = 1;
    wait_end(); @(negedge clk);
    check("R11 released", log_ba.size(), 4);
    if (log_ba.size() == 4) check("R11 dll bit", (log_w[3] >> 8) & 1, 1);
    clk_en_i = 0; c_dllr = 0;
    run(0);
    check("R11 no dll no hold", log_ba.size(), 4);
    clk_en_i = 1;

    // S9 requests and config changes during a sequence
    cfg_a();
    clear_log(); request(1);
    c_cl = 9;
    request(0);
    request(1);
    wait_end(); @(negedge clk);
    check("R12 count", log_ba.size(), 4);
    if (log_w.size() == 4) check("R12 snapshot", (log_w[3] >> 4) & 7, 2);
    clear_log();
    repeat (20) @(negedge clk);
    check("R12 no extra", log_ba.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule